// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes one active-low external interrupt pin and turns it into an interrupt request for the CPU. The pin is first synchronized to the system clock. It is then sensed in one of two ways. In level mode, the request follows the synchronized pin while the pin is low. In edge mode, a falling edge sets a pending latch. That latch stays set until the CPU acknowledges the interrupt or the block is reset.

Software sees an 8-bit control register through a simple byte register bus. The bus has an address, a write strobe, write data and combinational read data. Bit 7 of the register selects edge sensing, and bit 6 connects the pin to the request logic. The next address holds a reserved register that always reads zero. A mode input picks normal or special operation. In normal mode, the edge-select bit takes only the first write after reset. In special mode it can be rewritten freely. The request and acknowledge are plain control pins with no handshake.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x40 (edge select = 0, enable = 1) and `irq_req` is low.
- R2: Control register bits 5..0 always read 0, and writing ones to them has no effect. Bit 7 is edge select and bit 6 is enable.
- R3: In normal mode (`special_mode` = 0), bit 7 takes the value of the first control-register write after reset. Later writes leave bit 7 unchanged.
- R4: In special mode (`special_mode` = 1), bit 7 takes every control-register write, including writes made after the normal-mode lock has been set.
- R5: Bit 6 takes every control-register write, in both modes and whether or not bit 7 is locked.
- R6: With edge select = 0 and enable = 1, `irq_req` is high while the pin, delayed by two synchronizer flops, is low. It rises two clock edges after the pin falls and drops two edges after the pin rises.
- R7: With edge select = 1, a 1-to-0 change of the synchronized pin sets a pending latch. `irq_req` goes high three clock edges after the pin falls and stays high after the pin returns high.
- R8: The pending latch is cleared only by reset or by a one-cycle `irq_ack`. Clearing enable and then setting it again does not clear the latch.
- R9: With enable = 0, `irq_req` stays low whatever the pin and the pending latch do.
- R10: The address after the control register (`CTRL_ADDR`+1) reads 0x00. Writes to it change no state.
- R11: In edge mode, a pin that is held low after an acknowledge does not raise the request again. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | 1 = special mode (bit 7 always writable) |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_ack | input | 1 | One-cycle service acknowledge, clears the pending latch |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
Most wrong internal states in this block show up in the control register readback during the same cycle. Examples are a lost write-once lock or a bit 7 that changes when it should not. A pending latch that clears too early or sets when it should not changes `irq_req` within one cycle of the cause. A wrong synchronizer depth moves the request edge away from the two-cycle or three-cycle latency. The bench therefore samples `irq_req` at exact edge counts and follows every write with a readback.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned EDGE_BIT = 7;
  localparam int unsigned EN_BIT   = 6;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h40;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic special_mode,
  input  logic wr_ctrl,
  input  logic wr_edge,
  input  logic wr_en,
  output logic edge_sel,
  output logic enable,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel <= CTRL_RESET[EDGE_BIT];
      enable   <= CTRL_RESET[EN_BIT];
      locked   <= 1'b0;
    end else if (wr_ctrl) begin
      enable <= wr_en;
      if (special_mode || !locked) edge_sel <= wr_edge;
      if (!special_mode) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_sense.sv
module irq_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_sel,
  input  logic enable,
  input  logic ack,
  output logic pending,
  output logic irq_req
);
  logic pin_prev;
  logic fall;

  assign fall = pin_prev & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= 1'b1;
      pending  <= 1'b0;
    end else begin
      pin_prev <= pin_s;
      if (edge_sel && fall) pending <= 1'b1;
      else if (ack)         pending <= 1'b0;
    end
  end

  assign irq_req = enable & (edge_sel ? pending : ~pin_s);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pin_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CTRL_ADDR   = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              pin_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'(CTRL_ADDR + 1);

  logic pin_s;
  logic edge_sel;
  logic enable;
  logic wr_locked;
  logic pending;
  logic hit_ctrl;
  logic unused_wbits;

  assign hit_ctrl     = (reg_addr == A_CTRL);
  assign unused_wbits = ^reg_wdata[EN_BIT-1:0];

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_n),
    .pin_sync  (pin_s)
  );

  irq_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_ctrl      (reg_wr && hit_ctrl),
    .wr_edge      (reg_wdata[EDGE_BIT]),
    .wr_en        (reg_wdata[EN_BIT]),
    .edge_sel     (edge_sel),
    .enable       (enable),
    .locked       (wr_locked)
  );

  irq_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .edge_sel (edge_sel),
    .enable   (enable),
    .ack      (irq_ack),
    .pending  (pending),
    .irq_req  (irq_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[EDGE_BIT] = edge_sel;
      reg_rdata[EN_BIT]   = enable;
    end else if (reg_addr == A_RSVD) begin
      reg_rdata = '0;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_rdata,
  input logic              irq_ack,
  input logic              irq_req,
  input logic              pin_s,
  input logic              edge_sel,
  input logic              enable,
  input logic              wr_locked,
  input logic              pending
);
  // R3
  edge_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_locked && !special_mode && reg_wr && reg_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(edge_sel));

  // R7
  fall_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && $fell(pin_s)) |=> pending);

  // R8
  pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !irq_ack) |=> pending);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !edge_sel) |=> !pending);

  // R9
  off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq_req);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_ADDR + 1)) |-> (reg_rdata == 8'h00));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_rdata    (reg_rdata),
  .irq_ack      (irq_ack),
  .irq_req      (irq_req),
  .pin_s        (pin_s),
  .edge_sel     (edge_sel),
  .enable       (enable),
  .wr_locked    (wr_locked),
  .pending      (pending)
);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CTRL = 4'd14;
  localparam logic [AW-1:0] A_RSVD = 4'd15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          special_mode = 1'b0;
  logic          pin_n = 1'b1;
  logic [AW-1:0] reg_addr = A_CTRL;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          irq_ack = 1'b0;
  logic          irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .pin_n(pin_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = A_CTRL;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = A_CTRL;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; special_mode = mode; pin_n = 1'b1; irq_ack = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(A_CTRL, d); check(d, 8'h40, "R1 ctrl reset value");
    check({7'd0, irq_req}, 8'h00, "R1 irq_req low after reset");
    rd(A_RSVD, d); check(d, 8'h00, "R10 reserved reads zero");
  endtask

  task automatic t_special_writes();
    logic [7:0] d;
    wr(A_CTRL, 8'hFF); rd(A_CTRL, d); check(d, 8'hC0, "R2 low bits ignored, R4 edge set");
    wr(A_CTRL, 8'h40); rd(A_CTRL, d); check(d, 8'h40, "R4 edge cleared in special");
    wr(A_CTRL, 8'hC0); rd(A_CTRL, d); check(d, 8'hC0, "R4 edge set again");
    wr(A_RSVD, 8'hFF); rd(A_CTRL, d); check(d, 8'hC0, "R10 reserved write leaves ctrl");
    rd(A_RSVD, d); check(d, 8'h00, "R10 reserved still zero");
  endtask

  task automatic t_edge_mode();
    logic [7:0] d;
    pin_n = 1'b0;
    cycles(2); check({7'd0, irq_req}, 8'h00, "R7 not yet at edge 2");
    cycles(1); check({7'd0, irq_req}, 8'h01, "R7 request at edge 3");
    pin_n = 1'b1;
    cycles(5); check({7'd0, irq_req}, 8'h01, "R7 latched after pin high");
    wr(A_CTRL, 8'h80); check({7'd0, irq_req}, 8'h00, "R9 disabled masks pending");
    wr(A_CTRL, 8'hC0); check({7'd0, irq_req}, 8'h01, "R8 pending survives enable toggle");
    rd(A_CTRL, d); check(d, 8'hC0, "R5 enable rewritten");
    ack_pulse(); check({7'd0, irq_req}, 8'h00, "R8 ack clears pending");
  endtask

  task automatic t_held_low();
    pin_n = 1'b0;
    cycles(4); check({7'd0, irq_req}, 8'h01, "R7 second falling edge");
    ack_pulse();
    cycles(5); check({7'd0, irq_req}, 8'h00, "R11 held-low pin no retrigger");
    pin_n = 1'b1;
    cycles(3); check({7'd0, irq_req}, 8'h00, "R11 rising edge no request");
  endtask

  task automatic t_level_mode();
    wr(A_CTRL, 8'h00);
    pin_n = 1'b0;
    cycles(4); check({7'd0, irq_req}, 8'h00, "R9 level mode disabled");
    wr(A_CTRL, 8'h40); check({7'd0, irq_req}, 8'h01, "R6 level low enabled");
    pin_n = 1'b1;
    cycles(1); check({7'd0, irq_req}, 8'h01, "R6 still high one edge after release");
    cycles(1); check({7'd0, irq_req}, 8'h00, "R6 drops two edges after release");
    pin_n = 1'b0;
    cycles(1); check({7'd0, irq_req}, 8'h00, "R6 not yet at edge 1");
    cycles(1); check({7'd0, irq_req}, 8'h01, "R6 rises at edge 2");
    pin_n = 1'b1;
    cycles(3);
  endtask

  task automatic t_normal_lock();
    logic [7:0] d;
    wr(A_CTRL, 8'h80); rd(A_CTRL, d); check(d, 8'h80, "R3 first normal write taken");
    wr(A_CTRL, 8'h40); rd(A_CTRL, d); check(d, 8'hC0, "R3 edge locked, R5 enable set");
    wr(A_CTRL, 8'h00); rd(A_CTRL, d); check(d, 8'h80, "R5 enable cleared while locked");
    special_mode = 1'b1;
    wr(A_CTRL, 8'h40); rd(A_CTRL, d); check(d, 8'h40, "R4 special overrides lock");
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    t_reset_state();
    t_special_writes();
    t_edge_mode();
    t_held_low();
    t_level_mode();
    do_reset(1'b0);
    t_reset_state();
    t_normal_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule